// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block takes a received frame, delivered one byte per cycle with start and end markers, and lays it down in a circular receive area of local RAM. The RAM is organised in 256-byte pages, and the ring spans a first page and an end page supplied by configuration. Each stored frame becomes a record that opens with a four-byte descriptor. The descriptor holds the receive status, the page where the following record will start, and the 16-bit stored length. Frames shorter than the minimum are zero-padded before the descriptor is written.

Before it accepts a frame, the block compares its current-page pointer with a boundary page owned by the host. From the two it works out how many bytes are free. A frame is refused when the receiver is not running, when the ring is empty or inverted, or when free space is below the largest frame plus its descriptor. Frame bytes go to RAM as they arrive, starting four bytes into the record. The descriptor follows once the length is known. The block then moves the current page to the next record and pulses a receive-done event. The host can also load the current page directly.

Top module: `rxr_ring_writer`

## Requirements
- R1: After reset, `rx_busy`, `rx_done` and `ram_we` are 0 and `cur_page` is 0.
- R2: A frame is refused if `rx_run` is 0, or if `cfg_stop` <= `cfg_start`, or if free space is too small (R3). A refused frame causes no RAM write and no `rx_done`, and leaves `cur_page` unchanged.
- R3: Free space is counted in pages. When cur < boundary it is boundary − cur; otherwise it is (stop − start) − (cur − boundary), and this value may be negative. The frame is accepted only if 256 × free >= 1518.
- R4: Byte i of an accepted frame is written to base×256 + 4 + i, one write per cycle, in arrival order. The first write appears the cycle after the start byte is taken.
- R5: When the data write address reaches stop×256, it continues at start×256.
- R6: A frame shorter than 60 bytes is followed by zero bytes until 60 bytes are stored. A frame of 60 bytes or more gets no padding.
- R7: After the data, the descriptor is written at base×256 + 0..3. Byte 0 is status, byte 1 is next page, bytes 2 and 3 are the stored length + 4, low byte then high byte.
- R8: The status byte is 0x01. It is 0x21 when bit 0 of the first frame byte is set.
- R9: Next page = base + ceil((stored length + 8) / 256). If the result is >= stop, (stop − start) is subtracted.
- R10: `rx_done` is high for exactly one cycle, the cycle of the last descriptor write. From that cycle on, `cur_page` holds the next page.
- R11: `rx_busy` is high from the cycle after a start byte is taken until the record completes, or until the end byte of a refused frame. Any input taken while padding or writing the descriptor is ignored.
- R12: A host write (`cur_we`) loads `cur_page` only if the value is below `PMEM_END_PAGE` (128 by default). If it lands in the same cycle as record completion, the completion value wins.
- R13: If `cur_page` >= `PMEM_END_PAGE` when a frame is accepted, the record is placed at `cfg_start` instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_run | input | 1 | Receiver running |
| cfg_start | input | PAGE_W | First page of the ring |
| cfg_stop | input | PAGE_W | One past the last ring page |
| cfg_bound | input | PAGE_W | Host-owned boundary page |
| cur_we | input | 1 | Host load of the current page |
| cur_wdata | input | PAGE_W | Value for the current-page load |
| cur_page | output | PAGE_W | Current page pointer |
| rx_valid | input | 1 | Frame byte present |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_data | input | 8 | Frame byte |
| rx_busy | output | 1 | Frame in progress; new frames are held off |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | PAGE_W+8 | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| rx_done | output | 1 | One-cycle receive-done event |

## Verification
Two functions can fall on the same clock edge: a host load of the current page, and the pointer update at record completion. The bench watches the RAM port until it sees the third descriptor byte being written. It then raises `cur_we` for exactly one cycle, so the host load meets the final descriptor edge. The bench judges the result by requiring `cur_page` to hold the computed next page, not the host value, both in the done cycle and afterwards. A second overlap, a new start byte arriving while padding is in progress, is judged by the absence of any extra RAM write or event.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_DATA = 3'd1,
      ST_DROP = 3'd2,
      ST_PAD  = 3'd3,
      ST_HDR  = 3'd4
   } rxr_state_e;

   localparam logic [7:0] STAT_GOOD  = 8'h01;
   localparam logic [7:0] STAT_GROUP = 8'h20;
   localparam int         HDR_BYTES  = 4;
endpackage

// File: rtl/rxr_space_check.sv
module rxr_space_check #(
   parameter int PAGE_W     = 8,
   parameter int NEED_BYTES = 1518
) (
   input  logic              run,
   input  logic [PAGE_W-1:0] pg_start,
   input  logic [PAGE_W-1:0] pg_stop,
   input  logic [PAGE_W-1:0] pg_bound,
   input  logic [PAGE_W-1:0] pg_cur,
   output logic              accept
);
   localparam int SW      = PAGE_W + 3;
   localparam int NEED_PG = (NEED_BYTES + 255) / 256;
   localparam logic signed [SW-1:0] NEED_S = SW'(NEED_PG);

   logic signed [SW-1:0] s_start, s_stop, s_bound, s_cur, free_pg;

   assign s_start = $signed({3'b000, pg_start});
   assign s_stop  = $signed({3'b000, pg_stop});
   assign s_bound = $signed({3'b000, pg_bound});
   assign s_cur   = $signed({3'b000, pg_cur});

   // free room in pages; may go negative when pointers are inconsistent
   always_comb begin
      if (s_cur < s_bound) free_pg = s_bound - s_cur;
      else                 free_pg = (s_stop - s_start) - (s_cur - s_bound);
   end

   assign accept = run && (pg_stop > pg_start) && (free_pg >= NEED_S);
endmodule

// File: rtl/rxr_hdr_calc.sv
module rxr_hdr_calc import rxr_pkg::*; #(
   parameter int PAGE_W = 8,
   parameter int LEN_W  = 16
) (
   input  logic [PAGE_W-1:0] base_pg,
   input  logic [PAGE_W-1:0] pg_start,
   input  logic [PAGE_W-1:0] pg_stop,
   input  logic [LEN_W-1:0]  stored_len,
   input  logic              group,
   output logic [PAGE_W-1:0] next_pg,
   output logic [LEN_W-1:0]  total_len,
   output logic [7:0]        status
);
   localparam int SW = LEN_W + 1;

   logic [SW-1:0] span, npg, sum, stop_x, start_x, wrapped;

   assign total_len = stored_len + LEN_W'(HDR_BYTES);
   // record footprint: descriptor + data + 4 trailing bytes, rounded up to pages
   assign span    = {1'b0, stored_len} + SW'(HDR_BYTES + 4 + 255);
   assign npg     = span >> 8;
   assign sum     = SW'(base_pg) + npg;
   assign stop_x  = SW'(pg_stop);
   assign start_x = SW'(pg_start);
   assign wrapped = (sum >= stop_x) ? sum - (stop_x - start_x) : sum;
   assign next_pg = wrapped[PAGE_W-1:0];
   assign status  = group ? (STAT_GOOD | STAT_GROUP) : STAT_GOOD;
endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer import rxr_pkg::*; #(
   parameter int PAGE_W        = 8,
   parameter int LEN_W         = 16,
   parameter int MAX_FRAME     = 1514,
   parameter int MIN_FRAME     = 60,
   parameter int PMEM_END_PAGE = 128
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rx_run,
   input  logic [PAGE_W-1:0]   cfg_start,
   input  logic [PAGE_W-1:0]   cfg_stop,
   input  logic [PAGE_W-1:0]   cfg_bound,
   input  logic                cur_we,
   input  logic [PAGE_W-1:0]   cur_wdata,
   output logic [PAGE_W-1:0]   cur_page,
   input  logic                rx_valid,
   input  logic                rx_sof,
   input  logic                rx_eof,
   input  logic [7:0]          rx_data,
   output logic                rx_busy,
   output logic                ram_we,
   output logic [PAGE_W+7:0]   ram_addr,
   output logic [7:0]          ram_wdata,
   output logic                rx_done
);
   localparam int ADDR_W = PAGE_W + 8;
   localparam logic [PAGE_W:0] END_PG = (PAGE_W + 1)'(PMEM_END_PAGE);

   if (PAGE_W < 2)                  begin : g_bad_page  $error("PAGE_W too small");        end
   if (LEN_W < 12)                  begin : g_bad_len   $error("LEN_W cannot hold a frame"); end
   if (MIN_FRAME > MAX_FRAME)       begin : g_bad_min   $error("MIN_FRAME above MAX_FRAME"); end
   if (PMEM_END_PAGE > 2**PAGE_W)   begin : g_bad_end   $error("PMEM_END_PAGE out of range"); end

   rxr_state_e        state;
   logic [PAGE_W-1:0] cur_q, base_q, base_sel, next_pg;
   logic [ADDR_W-1:0] wptr, wptr_adv, first_addr, first_adv;
   logic [LEN_W-1:0]  len_q, len_inc, total_len;
   logic              group_q, accept, pad_need, host_ok;
   logic [1:0]        hdr_idx;
   logic [7:0]        status, hdr_byte;

   function automatic logic [ADDR_W-1:0] advance(input logic [ADDR_W-1:0] a,
                                                  input logic [PAGE_W-1:0] s_pg,
                                                  input logic [PAGE_W-1:0] e_pg);
      logic [ADDR_W-1:0] n;
      n = a + ADDR_W'(1);
      if (n == {e_pg, 8'h00}) n = {s_pg, 8'h00};
      return n;
   endfunction

   rxr_space_check #(.PAGE_W(PAGE_W), .NEED_BYTES(MAX_FRAME + HDR_BYTES)) u_space (
      .run      (rx_run),
      .pg_start (cfg_start),
      .pg_stop  (cfg_stop),
      .pg_bound (cfg_bound),
      .pg_cur   (cur_q),
      .accept   (accept)
   );

   rxr_hdr_calc #(.PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_hdr (
      .base_pg    (base_q),
      .pg_start   (cfg_start),
      .pg_stop    (cfg_stop),
      .stored_len (len_q),
      .group      (group_q),
      .next_pg    (next_pg),
      .total_len  (total_len),
      .status     (status)
   );

   assign base_sel   = ({1'b0, cur_q} >= END_PG) ? cfg_start : cur_q;
   assign first_addr = {base_sel, 8'h00} + ADDR_W'(HDR_BYTES);
   assign first_adv  = advance(first_addr, cfg_start, cfg_stop);
   assign wptr_adv   = advance(wptr, cfg_start, cfg_stop);
   assign len_inc    = (state == ST_IDLE) ? LEN_W'(1) : len_q + LEN_W'(1);
   assign host_ok    = ({1'b0, cur_wdata} < END_PG);

   if (MIN_FRAME > 0) begin : g_pad
      assign pad_need = (len_inc < LEN_W'(MIN_FRAME));
   end else begin : g_nopad
      assign pad_need = 1'b0;
   end

   always_comb begin
      unique case (hdr_idx)
         2'd0:    hdr_byte = status;
         2'd1:    hdr_byte = 8'(next_pg);
         2'd2:    hdr_byte = total_len[7:0];
         default: hdr_byte = total_len[15:8];
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cur_q     <= '0;
         base_q    <= '0;
         wptr      <= '0;
         len_q     <= '0;
         group_q   <= 1'b0;
         hdr_idx   <= '0;
         ram_we    <= 1'b0;
         ram_addr  <= '0;
         ram_wdata <= '0;
         rx_done   <= 1'b0;
      end else begin
         ram_we  <= 1'b0;
         rx_done <= 1'b0;
         if (cur_we && host_ok) cur_q <= cur_wdata;
         unique case (state)
            ST_IDLE: begin
               if (rx_valid && rx_sof) begin
                  if (accept) begin
                     ram_we    <= 1'b1;
                     ram_addr  <= first_addr;
                     ram_wdata <= rx_data;
                     wptr      <= first_adv;
                     len_q     <= len_inc;
                     group_q   <= rx_data[0];
                     base_q    <= base_sel;
                     hdr_idx   <= '0;
                     if (rx_eof) state <= pad_need ? ST_PAD : ST_HDR;
                     else        state <= ST_DATA;
                  end else if (!rx_eof) begin
                     state <= ST_DROP;
                  end
               end
            end
            ST_DATA: begin
               if (rx_valid) begin
                  ram_we    <= 1'b1;
                  ram_addr  <= wptr;
                  ram_wdata <= rx_data;
                  wptr      <= wptr_adv;
                  len_q     <= len_inc;
                  if (rx_eof) state <= pad_need ? ST_PAD : ST_HDR;
               end
            end
            ST_PAD: begin
               ram_we    <= 1'b1;
               ram_addr  <= wptr;
               ram_wdata <= 8'h00;
               wptr      <= wptr_adv;
               len_q     <= len_inc;
               if (!pad_need) state <= ST_HDR;
            end
            ST_HDR: begin
               ram_we    <= 1'b1;
               ram_addr  <= {base_q, 6'b000000, hdr_idx};
               ram_wdata <= hdr_byte;
               hdr_idx   <= hdr_idx + 2'd1;
               if (hdr_idx == 2'd3) begin
                  cur_q   <= next_pg;
                  rx_done <= 1'b1;
                  state   <= ST_IDLE;
               end
            end
            ST_DROP: begin
               if (rx_valid && rx_eof) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign cur_page = cur_q;
   assign rx_busy  = (state != ST_IDLE);
endmodule

// File: rtl/rxr_ring_writer_chk.sv
module rxr_ring_writer_chk #(
   parameter int PAGE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cur_we,
   input logic [PAGE_W-1:0] cur_page,
   input logic              rx_busy,
   input logic              ram_we,
   input logic              rx_done
);
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> !rx_done); // R10

   AST_DONE_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |-> ram_we); // R10

   AST_WRITE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (rx_busy || rx_done)); // R11

   AST_CUR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cur_page) |-> ($past(cur_we) || rx_done)); // R12

   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |-> (!rx_busy && $past(rx_busy))); // R11
endmodule

bind rxr_ring_writer rxr_ring_writer_chk #(.PAGE_W(PAGE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cur_we   (cur_we),
   .cur_page (cur_page),
   .rx_busy  (rx_busy),
   .ram_we   (ram_we),
   .rx_done  (rx_done)
);

// File: tb/rxr_ring_writer_bench.sv
`timescale 1ns/1ps
module rxr_ring_writer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_run = 1'b0;
   logic [7:0]  cfg_start = 8'h00, cfg_stop = 8'h00, cfg_bound = 8'h00;
   logic        cur_we = 1'b0;
   logic [7:0]  cur_wdata = 8'h00;
   logic [7:0]  cur_page;
   logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
   logic [7:0]  rx_data = 8'h00;
   logic        rx_busy, ram_we, rx_done;
   logic [15:0] ram_addr;
   logic [7:0]  ram_wdata;

   int checks = 0, failures = 0, cycles = 0;
   int m_cur = 0, exp_done = 0, seen_done = 0;
   int q_addr[$], q_data[$], q_next[$];
   string q_tag[$];
   int mon_a, mon_d, mon_n;
   string mon_t;

   always #10 clk = ~clk;

   rxr_ring_writer u_rxr_ring_writer (
      .clk(clk), .rst_n(rst_n), .rx_run(rx_run),
      .cfg_start(cfg_start), .cfg_stop(cfg_stop), .cfg_bound(cfg_bound),
      .cur_we(cur_we), .cur_wdata(cur_wdata), .cur_page(cur_page),
      .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
      .rx_busy(rx_busy), .ram_we(ram_we), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata), .rx_done(rx_done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int fbyte(input int first, input int i);
      return (i == 0) ? first : ((first + i * 13) & 255);
   endfunction

   // reference model: compare every RAM write and done event on each clock
   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         if (ram_we) begin
            if (q_addr.size() == 0) begin
               chk(1'b0, "R2/R11 unexpected write", int'(ram_addr), 0);
            end else begin
               mon_a = q_addr.pop_front();
               mon_d = q_data.pop_front();
               mon_t = q_tag.pop_front();
               chk(int'(ram_addr) == mon_a, {mon_t, " address"}, int'(ram_addr), mon_a);
               chk(int'(ram_wdata) == mon_d, {mon_t, " data"}, int'(ram_wdata), mon_d);
            end
         end
         if (rx_done) begin
            seen_done++;
            if (q_next.size() == 0) begin
               chk(1'b0, "R10 unexpected done", 1, 0);
            end else begin
               mon_n = q_next.pop_front();
               chk(int'(cur_page) == mon_n, "R10 pointer at done", int'(cur_page), mon_n);
               chk(q_addr.size() == 0, "R10 done with last write", q_addr.size(), 0);
            end
         end
      end
   end

   task automatic host_cur(input int v);
      @(negedge clk);
      cur_we = 1'b1; cur_wdata = 8'(v);
      @(negedge clk);
      cur_we = 1'b0;
      if (v < 128) m_cur = v;
      @(negedge clk);
      chk(int'(cur_page) == m_cur, "R12 host load", int'(cur_page), m_cur);
   endtask

   task automatic send_frame(input int n, input int first, input bit collide,
                             input int host_val, input bit inject, input string tag);
      int freep, acc, base, stored, total, nxt, a, st;
      int s  = int'(cfg_start);
      int e  = int'(cfg_stop);
      int bd = int'(cfg_bound);
      if (m_cur < bd) freep = bd - m_cur;
      else            freep = (e - s) - (m_cur - bd);
      acc = (rx_run && e > s && freep * 256 >= 1518) ? 1 : 0;
      base = (m_cur >= 128) ? s : m_cur;
      stored = (n < 60) ? 60 : n;
      total = stored + 4;
      nxt = base + (total + 4 + 255) / 256;
      if (nxt >= e) nxt = nxt - (e - s);
      if (acc != 0) begin
         a = base * 256 + 4;
         for (int i = 0; i < stored; i++) begin
            q_addr.push_back(a);
            q_data.push_back(i < n ? fbyte(first, i) : 0);
            q_tag.push_back(i >= n ? "R6 pad" : (a < base * 256 ? "R5 wrap" : "R4 data"));
            a++;
            if (a == e * 256) a = s * 256;
         end
         st = ((first & 1) != 0) ? 8'h21 : 8'h01;
         q_addr.push_back(base * 256);     q_data.push_back(st);              q_tag.push_back("R8 status");
         q_addr.push_back(base * 256 + 1); q_data.push_back(nxt);             q_tag.push_back("R9 next page");
         q_addr.push_back(base * 256 + 2); q_data.push_back(total & 255);     q_tag.push_back("R7 length low");
         q_addr.push_back(base * 256 + 3); q_data.push_back(total >> 8);      q_tag.push_back("R7 length high");
         q_next.push_back(nxt);
      end
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (i == 1) chk(rx_busy == 1'b1, "R11 busy after start", int'(rx_busy), 1);
         rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == n - 1);
         rx_data = 8'(fbyte(first, i));
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
      if (inject) begin
         rx_valid = 1'b1; rx_sof = 1'b1; rx_eof = 1'b1; rx_data = 8'hAA;
         @(negedge clk);
         rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
      end
      if (collide && acc != 0) begin
         for (int k = 0; k < 3000; k++) begin
            if (ram_we && int'(ram_addr) == base * 256 + 2) break;
            @(negedge clk);
         end
         cur_we = 1'b1; cur_wdata = 8'(host_val);
         @(negedge clk);
         cur_we = 1'b0;
      end
      for (int k = 0; k < 3000; k++) begin
         if (!rx_busy) break;
         @(negedge clk);
      end
      @(negedge clk);
      @(negedge clk);
      if (acc != 0) begin
         m_cur = nxt;
         exp_done++;
      end
      chk(int'(cur_page) == m_cur, {tag, " pointer after frame"}, int'(cur_page), m_cur);
      chk(seen_done == exp_done, {tag, " done count"}, seen_done, exp_done);
      chk(q_addr.size() == 0, {tag, " all writes seen"}, q_addr.size(), 0);
      chk(rx_busy == 1'b0, "R11 idle after frame", int'(rx_busy), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(rx_busy == 1'b0, "R1 busy", int'(rx_busy), 0);
      chk(rx_done == 1'b0, "R1 done", int'(rx_done), 0);
      chk(ram_we == 1'b0, "R1 write", int'(ram_we), 0);
      chk(cur_page == 8'h00, "R1 pointer", int'(cur_page), 0);
      rst_n = 1'b1;
      rx_run = 1'b1; cfg_start = 8'h40; cfg_stop = 8'h80; cfg_bound = 8'h40;
      host_cur(8'h40);
      send_frame(100, 8'h02, 1'b0, 0, 1'b0, "R4 R7 R8 R9 R10");
      send_frame(10, 8'h01, 1'b0, 0, 1'b1, "R6 R8 R11");
      host_cur(8'h7E);
      cfg_bound = 8'h50;
      send_frame(700, 8'h10, 1'b0, 0, 1'b0, "R5 R9");
      cfg_bound = 8'h46;
      send_frame(80, 8'h05, 1'b0, 0, 1'b0, "R3 refused");
      cfg_bound = 8'h47;
      send_frame(60, 8'h07, 1'b1, 8'h55, 1'b0, "R3 R6 R12 collision");
      rx_run = 1'b0;
      send_frame(70, 8'h09, 1'b0, 0, 1'b0, "R2 stopped");
      rx_run = 1'b1; cfg_stop = 8'h40;
      send_frame(70, 8'h0B, 1'b0, 0, 1'b0, "R2 empty ring");
      cfg_stop = 8'h80;
      host_cur(8'h90);
      cfg_start = 8'h70; cfg_stop = 8'h90; cfg_bound = 8'h8F;
      host_cur(8'h7E);
      send_frame(600, 8'h33, 1'b0, 0, 1'b0, "R9 R13 setup");
      send_frame(80, 8'h44, 1'b0, 0, 1'b0, "R13 base reset");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      wait (cycles > 150000);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule